// File: doc/BRIEF.md
# Ethernet receive status register

This block collects the outcome of every received Ethernet frame and of the receive DMA into one 32-bit status word with sticky bits. At the end of each frame the MAC pulses a single-cycle strobe and presents the frame's bit count, the CRC verdict and whether the PHY flagged a receive error at any point. The block then decides which error classes apply and latches them. FIFO overflow, FIFO parity, missed-frame counter rollover and the DMA events arrive as strobes that latch at once. The word also carries a read-only view of how many frames sit in the DMA receive buffer.

Software reads the word combinationally. It clears the writable sticky bits by writing ones to them. The rollover bit ignores bus writes entirely and is cleared only as a side effect of a read of the missed-frame counter, which arrives as a strobe. A single interrupt line is the OR of the sticky bits, each gated by its bit in an enable mask.

Top module: `eth_rx_status`

## Requirements
- R1: After reset the status word reads all zeros and the interrupt line is low.
- R2: Bit 1 sets on the end-of-frame strobe only when the bit count is not a multiple of eight, the CRC is bad and ignore-CRC mode is off.
- R3: Bit 2 sets on the end-of-frame strobe when the CRC is bad or the PHY receive-error flag is high.
- R4: Bit 3 sets in the cycle after the FIFO-full-on-write strobe.
- R5: Bit 4 sets on the end-of-frame strobe when the whole-byte length (bit count divided by eight, rounded down) exceeds 1518 and the long-frame enable is low.
- R6: Bit 5 sets in the cycle after the FIFO parity error strobe.
- R7: Bit 0 sets on the missed-counter rollover strobe. It clears only on the missed-counter read strobe, and bus writes never change it.
- R8: The DMA strobes set their bits as follows: frame stored sets bit 16, not owner sets bit 17, maximum size exceeded sets bit 18, buffer full sets bit 19, and length/type field written sets bit 20.
- R9: A write clears each of bits 1 to 5 and 16 to 20 whose data bit is one. A set event in the same cycle overrides the clear.
- R10: Bits 26:22 mirror the buffered-frame count and bit 21 reads one when that count is non-zero. Both ignore writes. Bits 15:6 and 31:27 always read zero.
- R11: The interrupt output is high exactly when some sticky bit (0 to 5, 16 to 20) is set together with the same bit of the enable mask.
- R12: The CRC, PHY-error, bit-count and control inputs have no effect in cycles without the end-of-frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameEnd | input | 1 | Single-cycle end-of-frame strobe |
| frameBits | input | BIT_CNT_W | Received frame length in bits |
| crcBad | input | 1 | Trailing CRC did not match |
| phyErrSeen | input | 1 | PHY raised receive error during the frame |
| ignoreCrc | input | 1 | Ignore-CRC mode control bit |
| longEn | input | 1 | Accept long frames control bit |
| fifoFullWr | input | 1 | Byte had to be stored while FIFO was full |
| fifoParErr | input | 1 | Parity error detected in receive FIFO |
| missRoll | input | 1 | Missed-frame counter wrapped |
| missCntRead | input | 1 | Missed-frame counter is being read |
| dmaFrameDone | input | 1 | DMA moved a whole frame to memory |
| dmaNotOwner | input | 1 | DMA found a descriptor it does not own |
| dmaMaxSizeOver | input | 1 | Frame exceeded the configured maximum |
| dmaBufFull | input | 1 | DMA receive buffer full |
| dmaLenTypeWr | input | 1 | Length/type field written to memory |
| bufFrameCnt | input | 5 | Frames held in the DMA receive buffer |
| regWrEn | input | 1 | Status word write strobe |
| regWrData | input | 32 | Write data, ones clear |
| irqMask | input | 32 | Per-bit interrupt enable |
| regRdData | output | 32 | Current status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench keeps the defaults: a 14-bit bit counter and a 1518-byte limit. With these, frame lengths run up to 2047 bytes, so random frames fall on both sides of the long-frame limit. Directed frames also sit exactly at 1518 bytes, at 1518 bytes plus seven bits, and at 1519 bytes. They probe the floor rounding that R5 depends on, with bit counts both aligned and unaligned to eight for R2. Set-versus-clear collisions and rollover writes are driven on purpose because random traffic seldom lines them up.

// File: rtl/eth_rx_status_pkg.sv
package eth_rx_status_pkg;

  localparam int REG_W   = 32;
  localparam int CNT_W   = 5;
  localparam int CNT_LSB = 22;
  localparam int MORE_BIT = 21;

  // bit positions of the sticky flags
  localparam int B_MISS  = 0;
  localparam int B_ALIGN = 1;
  localparam int B_CRC   = 2;
  localparam int B_OVF   = 3;
  localparam int B_LONG  = 4;
  localparam int B_PAR   = 5;
  localparam int B_DONE  = 16;
  localparam int B_NOOWN = 17;
  localparam int B_MSO   = 18;
  localparam int B_FULL  = 19;
  localparam int B_EARLY = 20;

  localparam logic [REG_W-1:0] W1C_MASK    = 32'h001F_003E;
  localparam logic [REG_W-1:0] STICKY_MASK = 32'h001F_003F;

  typedef struct packed {
    logic missSet;
    logic missClr;
    logic alignSet;
    logic crcSet;
    logic ovfSet;
    logic longSet;
    logic parSet;
    logic doneSet;
    logic noOwnSet;
    logic msoSet;
    logic fullSet;
    logic earlySet;
  } statStrobes_t;

endpackage

// File: rtl/eth_rx_status_ctrl.sv
module eth_rx_status_ctrl
  import eth_rx_status_pkg::*;
#(
  parameter int BIT_CNT_W       = 14,
  parameter int MAX_FRAME_BYTES = 1518
) (
  input  logic                 frameEnd,
  input  logic [BIT_CNT_W-1:0] frameBits,
  input  logic                 crcBad,
  input  logic                 phyErrSeen,
  input  logic                 ignoreCrc,
  input  logic                 longEn,
  input  logic                 fifoFullWr,
  input  logic                 fifoParErr,
  input  logic                 missRoll,
  input  logic                 missCntRead,
  input  logic                 dmaFrameDone,
  input  logic                 dmaNotOwner,
  input  logic                 dmaMaxSizeOver,
  input  logic                 dmaBufFull,
  input  logic                 dmaLenTypeWr,
  output statStrobes_t         strb
);

  localparam int BYTE_W = BIT_CNT_W - 3;
  localparam logic [BYTE_W-1:0] MAX_BYTES = BYTE_W'(MAX_FRAME_BYTES);

  logic [BYTE_W-1:0] wholeBytes;
  logic              partialByte;
  logic              tooLong;

  assign wholeBytes  = frameBits[BIT_CNT_W-1:3];
  assign partialByte = |frameBits[2:0];
  assign tooLong     = wholeBytes > MAX_BYTES;

  always_comb begin
    strb          = '0;
    // frame classification happens only on the end-of-frame strobe
    strb.alignSet = frameEnd && partialByte && crcBad && !ignoreCrc;
    strb.crcSet   = frameEnd && (crcBad || phyErrSeen);
    strb.longSet  = frameEnd && tooLong && !longEn;
    // immediate events
    strb.ovfSet   = fifoFullWr;
    strb.parSet   = fifoParErr;
    strb.missSet  = missRoll;
    strb.missClr  = missCntRead;
    strb.doneSet  = dmaFrameDone;
    strb.noOwnSet = dmaNotOwner;
    strb.msoSet   = dmaMaxSizeOver;
    strb.fullSet  = dmaBufFull;
    strb.earlySet = dmaLenTypeWr;
  end

endmodule

// File: rtl/eth_rx_status_dp.sv
module eth_rx_status_dp
  import eth_rx_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  statStrobes_t       strb,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [CNT_W-1:0]   bufFrameCnt,
  input  logic [REG_W-1:0]   irqMask,
  output logic [REG_W-1:0]   regRdData,
  output logic               irq
);

  logic [REG_W-1:0] sticky;
  logic [REG_W-1:0] setVec;
  logic [REG_W-1:0] clrVec;

  always_comb begin
    setVec          = '0;
    setVec[B_MISS]  = strb.missSet;
    setVec[B_ALIGN] = strb.alignSet;
    setVec[B_CRC]   = strb.crcSet;
    setVec[B_OVF]   = strb.ovfSet;
    setVec[B_LONG]  = strb.longSet;
    setVec[B_PAR]   = strb.parSet;
    setVec[B_DONE]  = strb.doneSet;
    setVec[B_NOOWN] = strb.noOwnSet;
    setVec[B_MSO]   = strb.msoSet;
    setVec[B_FULL]  = strb.fullSet;
    setVec[B_EARLY] = strb.earlySet;
  end

  always_comb begin
    clrVec         = regWrEn ? (regWrData & W1C_MASK) : '0;
    clrVec[B_MISS] = strb.missClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sticky <= '0;
    end else begin
      sticky <= ((sticky & ~clrVec) | setVec) & STICKY_MASK;
    end
  end

  always_comb begin
    regRdData = sticky;
    regRdData[CNT_LSB +: CNT_W] = bufFrameCnt;
    regRdData[MORE_BIT] = |bufFrameCnt;
  end

  assign irq = |(sticky & irqMask);

endmodule

// File: rtl/eth_rx_status.sv
module eth_rx_status
  import eth_rx_status_pkg::*;
#(
  parameter int BIT_CNT_W       = 14,
  parameter int MAX_FRAME_BYTES = 1518
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameEnd,
  input  logic [BIT_CNT_W-1:0] frameBits,
  input  logic                 crcBad,
  input  logic                 phyErrSeen,
  input  logic                 ignoreCrc,
  input  logic                 longEn,
  input  logic                 fifoFullWr,
  input  logic                 fifoParErr,
  input  logic                 missRoll,
  input  logic                 missCntRead,
  input  logic                 dmaFrameDone,
  input  logic                 dmaNotOwner,
  input  logic                 dmaMaxSizeOver,
  input  logic                 dmaBufFull,
  input  logic                 dmaLenTypeWr,
  input  logic [4:0]           bufFrameCnt,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  input  logic [31:0]          irqMask,
  output logic [31:0]          regRdData,
  output logic                 irq
);

  statStrobes_t strb;

  eth_rx_status_ctrl #(
    .BIT_CNT_W      (BIT_CNT_W),
    .MAX_FRAME_BYTES(MAX_FRAME_BYTES)
  ) ctrl_i (
    .frameEnd      (frameEnd),
    .frameBits     (frameBits),
    .crcBad        (crcBad),
    .phyErrSeen    (phyErrSeen),
    .ignoreCrc     (ignoreCrc),
    .longEn        (longEn),
    .fifoFullWr    (fifoFullWr),
    .fifoParErr    (fifoParErr),
    .missRoll      (missRoll),
    .missCntRead   (missCntRead),
    .dmaFrameDone  (dmaFrameDone),
    .dmaNotOwner   (dmaNotOwner),
    .dmaMaxSizeOver(dmaMaxSizeOver),
    .dmaBufFull    (dmaBufFull),
    .dmaLenTypeWr  (dmaLenTypeWr),
    .strb          (strb)
  );

  eth_rx_status_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .bufFrameCnt(bufFrameCnt),
    .irqMask    (irqMask),
    .regRdData  (regRdData),
    .irq        (irq)
  );

endmodule

// File: rtl/eth_rx_status_chk.sv
module eth_rx_status_chk #(
  parameter int BIT_CNT_W = 14
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 frameEnd,
  input logic [BIT_CNT_W-1:0] frameBits,
  input logic                 crcBad,
  input logic                 ignoreCrc,
  input logic                 longEn,
  input logic                 missCntRead,
  input logic                 dmaFrameDone,
  input logic [4:0]           bufFrameCnt,
  input logic [31:0]          irqMask,
  input logic [31:0]          regRdData,
  input logic                 irq
);

  AST_ALIGN_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(regRdData[1]) && regRdData[1]) |->
      $past(frameEnd && crcBad && !ignoreCrc && (frameBits[2:0] != 3'd0))); // R2

  AST_LONG_ENABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(frameEnd && longEn) && !$past(regRdData[4])) |-> !regRdData[4]); // R5

  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regRdData[0]) && !$past(missCntRead)) |-> regRdData[0]); // R7

  AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(dmaFrameDone) |-> regRdData[16]); // R9

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[15:6] == 10'd0) && (regRdData[31:27] == 5'd0)); // R10

  AST_COUNT_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[26:22] == bufFrameCnt) && (regRdData[21] == (bufFrameCnt != 5'd0))); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irq == |(regRdData[20:0] & irqMask[20:0])); // R11

  AST_NO_FRAME_NO_CRC: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(frameEnd) && !$past(regRdData[2])) |-> !regRdData[2]); // R12

endmodule

bind eth_rx_status eth_rx_status_chk #(.BIT_CNT_W(BIT_CNT_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .frameEnd    (frameEnd),
  .frameBits   (frameBits),
  .crcBad      (crcBad),
  .ignoreCrc   (ignoreCrc),
  .longEn      (longEn),
  .missCntRead (missCntRead),
  .dmaFrameDone(dmaFrameDone),
  .bufFrameCnt (bufFrameCnt),
  .irqMask     (irqMask),
  .regRdData   (regRdData),
  .irq         (irq)
);

// File: tb/eth_rx_status_tb_top.sv
module eth_rx_status_tb_top;

  localparam int BITS_W  = 14;
  localparam int MAXB    = 1518;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameEnd = 0, crcBad = 0, phyErrSeen = 0, ignoreCrc = 0, longEn = 0;
  logic [BITS_W-1:0] frameBits = '0;
  logic fifoFullWr = 0, fifoParErr = 0, missRoll = 0, missCntRead = 0;
  logic dmaFrameDone = 0, dmaNotOwner = 0, dmaMaxSizeOver = 0, dmaBufFull = 0, dmaLenTypeWr = 0;
  logic [4:0]  bufFrameCnt = '0;
  logic        regWrEn = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] irqMask = '0;
  logic [31:0] regRdData;
  logic        irq;

  int nChecks = 0;
  int nErrors = 0;
  logic [31:0] model = '0;

  always #2 clk = ~clk;

  eth_rx_status dut_i (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .frameBits(frameBits),
    .crcBad(crcBad), .phyErrSeen(phyErrSeen), .ignoreCrc(ignoreCrc), .longEn(longEn),
    .fifoFullWr(fifoFullWr), .fifoParErr(fifoParErr), .missRoll(missRoll),
    .missCntRead(missCntRead), .dmaFrameDone(dmaFrameDone), .dmaNotOwner(dmaNotOwner),
    .dmaMaxSizeOver(dmaMaxSizeOver), .dmaBufFull(dmaBufFull), .dmaLenTypeWr(dmaLenTypeWr),
    .bufFrameCnt(bufFrameCnt), .regWrEn(regWrEn), .regWrData(regWrData),
    .irqMask(irqMask), .regRdData(regRdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: apply the inputs held over the last edge
  task automatic updateModel();
    logic [31:0] nxt;
    nxt = model;
    if (regWrEn) begin
      for (int b = 1; b <= 5; b++)   if (regWrData[b]) nxt[b] = 1'b0;
      for (int b = 16; b <= 20; b++) if (regWrData[b]) nxt[b] = 1'b0;
    end
    if (missCntRead) nxt[0] = 1'b0;
    if (missRoll) nxt[0] = 1'b1;
    if (frameEnd) begin
      if (crcBad && (int'(frameBits) % 8 != 0) && !ignoreCrc) nxt[1] = 1'b1;
      if (crcBad || phyErrSeen) nxt[2] = 1'b1;
      if ((int'(frameBits) / 8 > MAXB) && !longEn) nxt[4] = 1'b1;
    end
    if (fifoFullWr)     nxt[3]  = 1'b1;
    if (fifoParErr)     nxt[5]  = 1'b1;
    if (dmaFrameDone)   nxt[16] = 1'b1;
    if (dmaNotOwner)    nxt[17] = 1'b1;
    if (dmaMaxSizeOver) nxt[18] = 1'b1;
    if (dmaBufFull)     nxt[19] = 1'b1;
    if (dmaLenTypeWr)   nxt[20] = 1'b1;
    model = nxt;
  endtask

  task automatic compareAll();
    logic expIrq;
    expIrq = 1'b0;
    for (int b = 0; b < 32; b++) if (model[b] && irqMask[b]) expIrq = 1'b1;
    chk("R7 miss roll",  {31'd0, regRdData[0]}, {31'd0, model[0]});
    chk("R2 align",      {31'd0, regRdData[1]}, {31'd0, model[1]});
    chk("R3 crc",        {31'd0, regRdData[2]}, {31'd0, model[2]});
    chk("R4 overflow",   {31'd0, regRdData[3]}, {31'd0, model[3]});
    chk("R5 long",       {31'd0, regRdData[4]}, {31'd0, model[4]});
    chk("R6 parity",     {31'd0, regRdData[5]}, {31'd0, model[5]});
    chk("R8 dma bits",   {27'd0, regRdData[20:16]}, {27'd0, model[20:16]});
    chk("R10 count",     {26'd0, regRdData[26:21]}, {26'd0, bufFrameCnt, bufFrameCnt != 5'd0});
    chk("R10 reserved",  {17'd0, regRdData[31:27], regRdData[15:6]}, 32'd0);
    chk("R11 irq",       {31'd0, irq}, {31'd0, expIrq});
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    if (rstN) updateModel();
    compareAll();
  endtask

  task automatic clearStrobes();
    frameEnd = 0; crcBad = 0; phyErrSeen = 0; fifoFullWr = 0; fifoParErr = 0;
    missRoll = 0; missCntRead = 0; dmaFrameDone = 0; dmaNotOwner = 0;
    dmaMaxSizeOver = 0; dmaBufFull = 0; dmaLenTypeWr = 0; regWrEn = 0; regWrData = '0;
  endtask

  task automatic sendFrame(input int bits, input logic bad, input logic phy);
    frameEnd = 1; frameBits = BITS_W'(bits); crcBad = bad; phyErrSeen = phy;
    cycle();
    clearStrobes();
  endtask

  task automatic writeClr(input logic [31:0] d);
    regWrEn = 1; regWrData = d;
    cycle();
    clearStrobes();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    irqMask = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset word", regRdData, 32'd0);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    rstN = 1'b1;
    cycle();

    // R12: classification inputs without the strobe do nothing
    crcBad = 1; phyErrSeen = 1; frameBits = 14'd16383;
    cycle();
    chk("R12 no strobe", regRdData, 32'd0);
    clearStrobes();

    // R2/R3: aligned vs unaligned bad CRC, ignore-CRC mode
    sendFrame(8 * 64, 1, 0);
    chk("R2 aligned no align err", {31'd0, regRdData[1]}, 32'd0);
    sendFrame(8 * 64 + 3, 1, 0);
    chk("R2 unaligned bad crc", {31'd0, regRdData[1]}, 32'd1);
    writeClr(32'h0000_0006);
    chk("R9 clear align crc", {29'd0, regRdData[2:0]}, 32'd0);
    ignoreCrc = 1;
    sendFrame(8 * 64 + 5, 1, 0);
    chk("R2 ignore crc", {31'd0, regRdData[1]}, 32'd0);
    ignoreCrc = 0;
    writeClr(32'h0000_0004);
    sendFrame(8 * 64, 0, 1);
    chk("R3 phy error", {31'd0, regRdData[2]}, 32'd1);
    writeClr(32'h0000_0004);

    // R5 boundaries
    sendFrame(8 * MAXB, 0, 0);
    chk("R5 at limit", {31'd0, regRdData[4]}, 32'd0);
    sendFrame(8 * MAXB + 7, 0, 0);
    chk("R5 limit plus bits", {31'd0, regRdData[4]}, 32'd0);
    longEn = 1;
    sendFrame(8 * (MAXB + 1), 0, 0);
    chk("R5 long enabled", {31'd0, regRdData[4]}, 32'd0);
    longEn = 0;
    sendFrame(8 * (MAXB + 1), 0, 0);
    chk("R5 over limit", {31'd0, regRdData[4]}, 32'd1);

    // R4/R6 strobes
    fifoFullWr = 1; cycle(); clearStrobes();
    fifoParErr = 1; cycle(); clearStrobes();
    chk("R4 R6 set", {30'd0, regRdData[5], regRdData[3]}, 32'd3);

    // R7: rollover immune to writes, cleared by counter read
    missRoll = 1; cycle(); clearStrobes();
    writeClr(32'hFFFF_FFFF);
    chk("R7 write immune", {31'd0, regRdData[0]}, 32'd1);
    missCntRead = 1; cycle(); clearStrobes();
    chk("R7 read clears", {31'd0, regRdData[0]}, 32'd0);
    missRoll = 1; missCntRead = 1; cycle(); clearStrobes();
    chk("R7 set beats read", {31'd0, regRdData[0]}, 32'd1);
    missCntRead = 1; cycle(); clearStrobes();

    // R8 one at a time
    dmaNotOwner = 1; cycle(); clearStrobes();
    chk("R8 not owner bit17", {27'd0, regRdData[20:16]}, 32'h2);
    dmaLenTypeWr = 1; cycle(); clearStrobes();
    chk("R8 len type bit20", {27'd0, regRdData[20:16]}, 32'h12);
    writeClr(32'h001F_0000);

    // R9: set wins over clear in same cycle
    dmaFrameDone = 1; regWrEn = 1; regWrData = 32'h0001_0000;
    cycle(); clearStrobes();
    chk("R9 set wins", {31'd0, regRdData[16]}, 32'd1);

    // R10: writes to read-only count bits
    bufFrameCnt = 5'd17;
    writeClr(32'h07E0_0000);
    chk("R10 count ignores write", {26'd0, regRdData[26:21]}, {26'd0, 5'd17, 1'b1});

    // R11: masked interrupt
    irqMask = 32'h0000_0001;
    cycle();
    chk("R11 masked off", {31'd0, irq}, 32'd0);
    writeClr(32'hFFFF_FFFF);

    // random traffic, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      frameEnd       = ($urandom % 4) == 0;
      frameBits      = BITS_W'($urandom);
      crcBad         = ($urandom % 3) == 0;
      phyErrSeen     = ($urandom % 8) == 0;
      ignoreCrc      = ($urandom % 4) == 0;
      longEn         = ($urandom % 4) == 0;
      fifoFullWr     = ($urandom % 16) == 0;
      fifoParErr     = ($urandom % 16) == 0;
      missRoll       = ($urandom % 16) == 0;
      missCntRead    = ($urandom % 8) == 0;
      dmaFrameDone   = ($urandom % 8) == 0;
      dmaNotOwner    = ($urandom % 16) == 0;
      dmaMaxSizeOver = ($urandom % 16) == 0;
      dmaBufFull     = ($urandom % 16) == 0;
      dmaLenTypeWr   = ($urandom % 8) == 0;
      regWrEn        = ($urandom % 5) == 0;
      regWrData      = $urandom;
      bufFrameCnt    = 5'($urandom);
      if (($urandom % 32) == 0) irqMask = $urandom;
      cycle();
    end
    clearStrobes();
    cycle();

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule